// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block sits in front of a bank of eighteen 16-bit counter channels, organised as three groups, each holding two timers of three channels. For every channel it keeps a clock-source number and a gate-source number, and from those it produces a per-channel count enable and a per-channel gate level. The counters themselves live elsewhere; they consume only `clkEn` and `gateOut`.

Software programs the routing through six write-only byte registers, one clock-select and one gate-select per group. Each byte carries a timer bit, a 2-bit channel field and a 5-bit source number whose upper two bits are held apart from the lower three. Reference clocks are not separate clock nets. They are single-cycle enable pulses divided down from the 20 MHz system clock, so every consumer stays in one clock domain.

Top module: `ctr_src_router`

## Requirements
- R1: After reset every channel uses clock source 0 and gate source 0, so `gateOut` is all ones and `clkEn` follows only the dedicated clock pins.
- R2: Clock-select registers for groups 0, 1 and 2 are at byte addresses 0x18, 0x19 and 0x1A. Gate-select registers are at 0x1B, 0x1C and 0x1D. A write to any other address changes nothing.
- R3: In a written byte, bit 5 picks the timer and bits 4:3 pick the channel. The source number is {bits 7:6, bits 2:0}. The target channel index is (group*2 + timer)*3 + channel.
- R4: A write whose channel field is 3 is ignored and leaves both tables unchanged.
- R5: With `enhMode` low, only sources 0 to 7 are accepted and a write naming 8 to 31 is ignored. With `enhMode` high, sources 0 to 31 are accepted.
- R6: Clock source 0 gives a one-cycle enable in the cycle where the channel's `extClk` bit is high and was low at the previous clock edge.
- R7: Clock sources 1 to 5 pulse once every 2, 20, 200, 2000 and 20000 system cycles respectively. These correspond to 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz.
- R8: Clock source 11 enables every cycle (20 MHz). All other clock sources (6 to 10 and 12 to 31) give a constant 0.
- R9: Gate source 0 is constant 1, and gate source 1 follows the channel's `extGate` bit. Every other gate source reads as 0.
- R10: A clock-select write never alters a gate routing and a gate-select write never alters a clock routing. Each accepted write changes exactly one channel's entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz system clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register byte address |
| wrData | input | 8 | Packed selection byte |
| enhMode | input | 1 | Extended source range enable |
| extClk | input | 18 | Dedicated clock pin per channel (synchronous) |
| extGate | input | 18 | Dedicated gate pin per channel |
| clkEn | output | 18 | Selected count enable per channel |
| gateOut | output | 18 | Selected gate level per channel |

## Verification
A table of writes covers several cases:
- It reaches channels in every group and both timers, which separates the timer bit, the channel field and the group offset in the index arithmetic.
- It includes bytes with the upper source bits set, in each mode, which separates the split-field assembly and the mode range check.
- It includes writes to the neighbouring addresses 0x17 and 0x1E, and writes with channel field 3, each of which must leave every output as it was.

After every write, the full enable and gate vectors are compared while a fixed bit pattern drives the external pins. That pattern exposes a write landing on the wrong channel. A final run routes one channel to each reference rate and to the full-rate source, and counts pulses over one 20000-cycle window. The counts must come out exactly at each divide ratio.

// File: rtl/ctr_src_pkg.sv
package ctr_src_pkg;
  localparam int N_GROUPS = 3;
  localparam int N_TIMERS = 2;
  localparam int N_CHAN = 3;
  localparam int NCH = N_GROUPS * N_TIMERS * N_CHAN;
  localparam int IDX_W = $clog2(NCH);
  localparam int SRC_W = 5;
  localparam int STD_SRC_LIMIT = 8;
  localparam int N_REF = 5;
  localparam int FAST_SRC = 11;

  typedef struct packed {
    logic clkWr;
    logic gateWr;
    logic [IDX_W-1:0] chIdx;
    logic [SRC_W-1:0] src;
  } selStrobe_t;
endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
  parameter int FIRST_DIV = 2,
  parameter int DECADE = 10,
  parameter int STAGES = 5
) (
  input  logic clk,
  input  logic rstN,
  output logic [STAGES-1:0] tick
);
  localparam int W0 = (FIRST_DIV > 1) ? $clog2(FIRST_DIV) : 1;
  localparam int WD = $clog2(DECADE);

  logic [W0-1:0] firstCnt;

  always_ff @(posedge clk) begin
    if (!rstN) firstCnt <= '0;
    else if (tick[0]) firstCnt <= '0;
    else firstCnt <= firstCnt + 1'b1;
  end
  assign tick[0] = (firstCnt == W0'(FIRST_DIV - 1));

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    logic [WD-1:0] decCnt;
    logic decLast;
    assign decLast = (decCnt == WD'(DECADE - 1));
    always_ff @(posedge clk) begin
      if (!rstN) decCnt <= '0;
      else if (tick[k-1]) decCnt <= decLast ? '0 : decCnt + 1'b1;
    end
    assign tick[k] = tick[k-1] && decLast;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_chk
    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
      tick[k] |=> !tick[k]);
  end
endmodule

// File: rtl/src_ctrl.sv
module src_ctrl
  import ctr_src_pkg::*;
#(
  parameter logic [7:0] CLK_BASE = 8'h18,
  parameter logic [7:0] GATE_BASE = 8'h1B
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic enhMode,
  output selStrobe_t strb
);
  logic [SRC_W-1:0] srcNum;
  logic timerSel;
  logic [1:0] chanSel;
  logic [7:0] clkOff, gateOff, grpOff;
  logic clkHit, gateHit, legal;

  // source number is split: high part in bits 7:6, low part in bits 2:0
  assign srcNum = {wrData[7:6], wrData[2:0]};
  assign timerSel = wrData[5];
  assign chanSel = wrData[4:3];

  assign clkOff = wrAddr - CLK_BASE;
  assign gateOff = wrAddr - GATE_BASE;
  assign clkHit = (wrAddr >= CLK_BASE) && (int'(clkOff) < N_GROUPS);
  assign gateHit = (wrAddr >= GATE_BASE) && (int'(gateOff) < N_GROUPS);
  assign grpOff = clkHit ? clkOff : gateOff;

  assign legal = (int'(chanSel) < N_CHAN) &&
                 (enhMode || (int'(srcNum) < STD_SRC_LIMIT));

  always_comb begin
    strb.clkWr = wrEn && clkHit && legal;
    strb.gateWr = wrEn && gateHit && legal;
    strb.chIdx = IDX_W'((int'(grpOff) * N_TIMERS + int'(timerSel)) * N_CHAN
                        + int'(chanSel));
    strb.src = srcNum;
  end

  // R4
  chan3_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[4:3] == 2'd3) |-> !(strb.clkWr || strb.gateWr));

  // R5
  std_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !enhMode && wrData[7:6] != 2'b00) |-> !(strb.clkWr || strb.gateWr));

  // R2
  one_table_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clkWr, strb.gateWr}));

  // R10
  chidx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clkWr || strb.gateWr) |-> (int'(strb.chIdx) < NCH));
endmodule

// File: rtl/src_datapath.sv
module src_datapath
  import ctr_src_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  selStrobe_t strb,
  input  logic [N_REF-1:0] refTick,
  input  logic [NCH-1:0] extClk,
  input  logic [NCH-1:0] extGate,
  output logic [NCH-1:0] clkEn,
  output logic [NCH-1:0] gateOut
);
  logic [NCH-1:0][SRC_W-1:0] clkSel;
  logic [NCH-1:0][SRC_W-1:0] gateSel;
  logic [NCH-1:0] extClkPrev;
  logic [N_REF:0] tickVec;

  assign tickVec = {refTick, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSel <= '0;
      gateSel <= '0;
      extClkPrev <= '0;
    end else begin
      extClkPrev <= extClk;
      if (strb.clkWr) clkSel[strb.chIdx] <= strb.src;
      if (strb.gateWr) gateSel[strb.chIdx] <= strb.src;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [SRC_W-1:0] cs, gs;
    logic ckBit, gtBit;
    assign cs = clkSel[i];
    assign gs = gateSel[i];

    always_comb begin
      if (cs == '0) ckBit = extClk[i] & ~extClkPrev[i];
      else if (int'(cs) <= N_REF) ckBit = tickVec[cs];
      else if (int'(cs) == FAST_SRC) ckBit = 1'b1;
      else ckBit = 1'b0;
    end

    always_comb begin
      case (gs)
        SRC_W'(0): gtBit = 1'b1;
        SRC_W'(1): gtBit = extGate[i];
        default:   gtBit = 1'b0;
      endcase
    end

    assign clkEn[i] = ckBit;
    assign gateOut[i] = gtBit;

    // R6
    pin_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clkSel[i] == '0 && clkEn[i]) |-> (extClk[i] && !extClkPrev[i]));

    // R9
    gate_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      (gateSel[i] == '0) |-> gateOut[i]);
  end

  // R10
  clk_table_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clkWr |=> $stable(clkSel));

  // R10
  gate_table_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.gateWr |=> $stable(gateSel));
endmodule

// File: rtl/ctr_src_router.sv
module ctr_src_router
  import ctr_src_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic enhMode,
  input  logic [NCH-1:0] extClk,
  input  logic [NCH-1:0] extGate,
  output logic [NCH-1:0] clkEn,
  output logic [NCH-1:0] gateOut
);
  selStrobe_t strb;
  logic [N_REF-1:0] refTick;

  src_ctrl #(.CLK_BASE(8'h18), .GATE_BASE(8'h1B)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .enhMode(enhMode), .strb(strb)
  );

  ref_tick_gen #(.FIRST_DIV(2), .DECADE(10), .STAGES(N_REF)) u_ticks (
    .clk(clk), .rstN(rstN), .tick(refTick)
  );

  src_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .refTick(refTick),
    .extClk(extClk), .extGate(extGate), .clkEn(clkEn), .gateOut(gateOut)
  );
endmodule

// File: tb/ctr_src_router_tb.sv
module ctr_src_router_tb;
  import ctr_src_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, wrEn, enhMode;
  logic [7:0] wrAddr, wrData;
  logic [NCH-1:0] extClk, extGate, clkEn, gateOut;

  ctr_src_router u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .enhMode(enhMode), .extClk(extClk), .extGate(extGate),
    .clkEn(clkEn), .gateOut(gateOut)
  );

  localparam logic [NCH-1:0] PAT_CLK = 18'h15A3C;
  localparam logic [NCH-1:0] PAT_GATE = 18'h2B6D9;

  typedef struct packed { logic enh; logic [7:0] addr; logic [7:0] data; } vec_t;
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h1B, 8'h01},  // R3 gate grp0 t0 ch0 src1 -> idx0
    '{1'b0, 8'h1C, 8'h29},  // R3 gate grp1 t1 ch1 src1 -> idx10
    '{1'b0, 8'h1D, 8'h11},  // R3 gate grp2 t0 ch2 src1 -> idx14
    '{1'b0, 8'h1D, 8'h19},  // R4 channel field 3 ignored
    '{1'b0, 8'h1B, 8'h41},  // R5 src9 in standard mode ignored
    '{1'b1, 8'h1B, 8'h41},  // R5 src9 accepted in enhanced, gate reads 0
    '{1'b1, 8'h1E, 8'h00},  // R2 address above range ignored
    '{1'b1, 8'h17, 8'h28},  // R2 address below range ignored
    '{1'b0, 8'h18, 8'h27},  // R8 clk idx3 src7 undefined -> 0
    '{1'b1, 8'h19, 8'h4B},  // R8 clk idx7 src11 every cycle
    '{1'b0, 8'h1A, 8'h4B},  // R5 src11 standard mode ignored
    '{1'b1, 8'h1A, 8'hC8},  // R3 clk idx13 src24 upper bits
    '{1'b0, 8'h1D, 8'h10},  // R9 idx14 gate back to src0
    '{1'b0, 8'h18, 8'h20}   // R6 idx3 clock back to pin
  };

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [SRC_W-1:0] mClk [NCH];
  logic [SRC_W-1:0] mGate [NCH];

  function automatic void modelWrite(logic enh, logic [7:0] addr, logic [7:0] data);
    bit isClk = (addr >= 8'h18) && (addr <= 8'h1A);
    bit isGate = (addr >= 8'h1B) && (addr <= 8'h1D);
    int g = isClk ? int'(addr) - 'h18 : int'(addr) - 'h1B;
    int ch = int'(data[4:3]);
    int src = int'({data[7:6], data[2:0]});
    int idx = (g * 2 + int'(data[5])) * 3 + ch;
    if ((isClk || isGate) && ch != 3 && (enh || src < 8)) begin
      if (isClk) mClk[idx] = SRC_W'(src);
      else mGate[idx] = SRC_W'(src);
    end
  endfunction

  function automatic logic [NCH-1:0] expGate(logic [NCH-1:0] g);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++)
      r[i] = (mGate[i] == 0) ? 1'b1 : (mGate[i] == 1) ? g[i] : 1'b0;
    return r;
  endfunction

  function automatic logic [NCH-1:0] expClk(logic [NCH-1:0] rise);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++)
      r[i] = (mClk[i] == 0) ? rise[i] : (mClk[i] == 11) ? 1'b1 : 1'b0;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic enh, logic [7:0] addr, logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; enhMode = enh; wrAddr = addr; wrData = data; extClk = '0;
    @(posedge clk);
    modelWrite(enh, addr, data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int cnt [6];
    int expCnt [6];
    expCnt = '{10000, 1000, 100, 10, 1, 20000};
    for (int i = 0; i < NCH; i++) begin mClk[i] = '0; mGate[i] = '0; end
    rstN = 1'b0; wrEn = 1'b0; enhMode = 1'b0; wrAddr = '0; wrData = '0;
    extClk = '0; extGate = PAT_GATE;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state: all gates high, clocks follow pin edges
    extClk = PAT_CLK;
    #1;
    check("R1 gate after reset", 32'(gateOut), 32'({NCH{1'b1}}));
    check("R1 clk after reset", 32'(clkEn), 32'(PAT_CLK));

    // vector table: R2 R3 R4 R5 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      doWrite(VEC[v].enh, VEC[v].addr, VEC[v].data);
      extClk = PAT_CLK;
      #1;
      check($sformatf("R3 vec%0d gate", v), 32'(gateOut), 32'(expGate(PAT_GATE)));
      check($sformatf("R3 vec%0d clk", v), 32'(clkEn), 32'(expClk(PAT_CLK)));
    end

    // R9 gate source 1 tracks live pin
    extGate = ~PAT_GATE;
    #1;
    check("R9 gate follows pin", 32'(gateOut), 32'(expGate(~PAT_GATE)));

    // R6 level held high gives no enable
    @(negedge clk); extClk = '1;
    @(negedge clk); #1;
    check("R6 held high no edge", 32'(clkEn), 32'(expClk('0)));
    @(negedge clk); extClk = '0; #1;
    check("R6 falling no edge", 32'(clkEn), 32'(expClk('0)));

    // R7 / R8 reference rates on idx0..5
    doWrite(1'b1, 8'h18, 8'h01);
    doWrite(1'b1, 8'h18, 8'h0A);
    doWrite(1'b1, 8'h18, 8'h13);
    doWrite(1'b1, 8'h18, 8'h24);
    doWrite(1'b1, 8'h18, 8'h2D);
    doWrite(1'b1, 8'h18, 8'h73);
    #1;
    check("R10 gates unchanged by clock writes", 32'(gateOut), 32'(expGate(~PAT_GATE)));
    for (int k = 0; k < 6; k++) cnt[k] = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk); #1;
      for (int k = 0; k < 6; k++) cnt[k] += int'(clkEn[k]);
    end
    for (int k = 0; k < 5; k++)
      check($sformatf("R7 ref source %0d pulse count", k + 1), 32'(cnt[k]), 32'(expCnt[k]));
    check("R8 full-rate source count", 32'(cnt[5]), 32'(expCnt[5]));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule